// File: doc/BRIEF.md
# PCI Window Configuration Register File

This block is the register bank behind the address windows of a PCI host bridge. It holds four sets of window registers and one 64-bit control word. Each set has a base register, a mask register and a translated base register. A translation unit next to it reads all thirteen registers at once from parallel outputs. Software reaches the same registers through a simple request port, which carries a valid strobe, an address, a byte count, a write flag and write data.

Every request is answered exactly one clock later with a response valid, an error flag and read data. Each register sits in its own 64-byte slot within a 4 KB region that starts at a parameter base address. A few slots are stubs. Some of these read as zero and take writes silently. One reads as zero but rejects writes. Every other slot, every access that is not 8 bytes, and every address outside the region returns an error response. An error response carries zero data and changes no register.

Top module: `pci_window_regs`

## Requirements
- R1: After reset, all twelve window registers (base, mask and translated base for each of the four windows) are zero, the control word is 64'h0000_0021_0010_0000 (bit 20 set, bit 32 set, field 39:36 equal to 2), and rsp_valid is low.
- R2: The slot index is (req_addr - BASE_ADDR) >> 6, and the low six address bits are ignored. The slot map is as follows: slots 0-3 are window base 0-3, slots 4-7 are window mask 0-3, slots 8-11 are translated base 0-3, and slot 12 is the control word.
- R3: A valid 8-byte write to slots 0-12 updates the register on the clock edge that accepts the request. The new value appears on the parallel outputs after that edge.
- R4: Every request gets rsp_valid on the following cycle. A valid 8-byte read of slots 0-12 returns the stored value with rsp_err low.
- R5: Slot 15 (error status) reads as zero without error. A write to it completes without error and changes nothing.
- R6: Slot 19 (invalidate-all) reads as zero without error. A write to it completes without error and changes nothing.
- R7: Slot 16 (error mask) reads as zero without error. A write to it returns rsp_err and changes nothing.
- R8: Slots 13, 14, 17, 18, 20, 21 and 22-63 are unsupported for both reads and writes. They return rsp_err with zero data, and no register changes.
- R9: A request whose req_size is not 8 returns rsp_err with zero data and changes nothing.
- R10: A request below BASE_ADDR, or at or beyond BASE_ADDR + 4096, returns rsp_err with zero data and changes nothing.
- R11: A cycle with no request yields rsp_valid low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Response error flag |
| rsp_rdata | output | 64 | Read data, zero on error and on writes |
| win_base_o | output | 256 | Four window base registers, window 0 in bits 63:0 |
| win_mask_o | output | 256 | Four window mask registers, window 0 in bits 63:0 |
| xlat_base_o | output | 256 | Four translated base registers, window 0 in bits 63:0 |
| ctrl_o | output | 64 | Control word |

## Verification
The hardest case to reach is a rejected access that would corrupt state if decoded badly. Examples are a write to the error-mask slot, a write with a wrong size, or an address just past the region that aliases slot 0 after truncation. Each rejected access must leave all thirteen registers unchanged. To reach these cases, the random stimulus first fills every register with distinct data. Unsupported slots, odd sizes and out-of-range addresses are then mixed into the traffic. After each access the bench compares every parallel output against its model, so an unwanted write shows up immediately.

// File: rtl/pci_window_regs.sv
module pci_window_regs #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0001_0000,
  parameter int SPAN = 4096,
  parameter logic [63:0] CTRL_RST = 64'h0000_0021_0010_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_rdata,
  output logic [255:0]      win_base_o,
  output logic [255:0]      win_mask_o,
  output logic [255:0]      xlat_base_o,
  output logic [63:0]       ctrl_o
);
  localparam int NWIN  = 4;
  localparam int OFF_W = $clog2(SPAN);
  localparam int IDX_W = OFF_W - 6;

  logic [63:0] wbase [NWIN];
  logic [63:0] wmask [NWIN];
  logic [63:0] xbase [NWIN];
  logic [63:0] ctrl;

  logic [ADDR_W-1:0] offset;
  logic              in_range;
  logic [IDX_W-1:0]  idx;
  logic              ok;
  logic [63:0]       rd_val;
  logic              wr_en;

  assign offset   = req_addr - BASE_ADDR;
  assign in_range = (req_addr >= BASE_ADDR) && (offset < ADDR_W'(SPAN));
  assign idx      = offset[OFF_W-1:6];
  assign wr_en    = req_valid && req_write && ok;

  always_comb begin
    ok     = 1'b0;
    rd_val = '0;
    if (in_range && req_size == 4'd8) begin
      if (idx < IDX_W'(4)) begin
        ok = 1'b1; rd_val = wbase[idx[1:0]];
      end else if (idx < IDX_W'(8)) begin
        ok = 1'b1; rd_val = wmask[idx[1:0]];
      end else if (idx < IDX_W'(12)) begin
        ok = 1'b1; rd_val = xbase[idx[1:0]];
      end else if (idx == IDX_W'(12)) begin
        ok = 1'b1; rd_val = ctrl;
      end else if (idx == IDX_W'(15) || idx == IDX_W'(19)) begin
        ok = 1'b1;
      end else if (idx == IDX_W'(16)) begin
        ok = !req_write;
      end
    end
  end

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wbase[i] <= '0;
        wmask[i] <= '0;
        xbase[i] <= '0;
      end else if (wr_en) begin
        if (idx == IDX_W'(i))     wbase[i] <= req_wdata;
        if (idx == IDX_W'(i + 4)) wmask[i] <= req_wdata;
        if (idx == IDX_W'(i + 8)) xbase[i] <= req_wdata;
      end
    end
    assign win_base_o[64*i +: 64]  = wbase[i];
    assign win_mask_o[64*i +: 64]  = wmask[i];
    assign xlat_base_o[64*i +: 64] = xbase[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          ctrl <= CTRL_RST;
    else if (wr_en && idx == IDX_W'(12)) ctrl <= req_wdata;
  end
  assign ctrl_o = ctrl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !ok;
      rsp_rdata <= (req_valid && ok && !req_write) ? rd_val : '0;
    end
  end
endmodule

module pci_window_regs_chk #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0001_0000,
  parameter int SPAN = 4096
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_size,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [63:0]       rsp_rdata,
  input logic [255:0]      win_base_o,
  input logic [255:0]      win_mask_o,
  input logic [255:0]      xlat_base_o,
  input logic [63:0]       ctrl_o
);
  a_r4_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r8_err_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> rsp_rdata == 64'd0);
  a_r9_bad_size_err: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 4'd8) |=> rsp_err);
  a_r10_out_of_range_err: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr < BASE_ADDR || req_addr - BASE_ADDR >= ADDR_W'(SPAN))) |=> rsp_err);
  a_r3_regs_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> ($stable(win_base_o) && $stable(win_mask_o)
                                   && $stable(xlat_base_o) && $stable(ctrl_o)));
endmodule

bind pci_window_regs pci_window_regs_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .SPAN(SPAN))
  u_chk (.*);

// File: tb/tb_pci_window_regs.sv
module tb_pci_window_regs;
  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam logic [63:0] CRST = 64'h0000_0021_0010_0000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [31:0] req_addr = 0;
  logic [3:0] req_size = 0;
  logic [63:0] req_wdata = 0;
  logic rsp_valid, rsp_err;
  logic [63:0] rsp_rdata, ctrl_o;
  logic [255:0] win_base_o, win_mask_o, xlat_base_o;

  int checks = 0, fails = 0;
  logic [63:0] m [13];

  always #2.5 clk = ~clk;

  pci_window_regs #(.ADDR_W(32), .BASE_ADDR(BASE)) dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_outputs(input string tag);
    for (int i = 0; i < 4; i++) begin
      chk(tag, win_base_o[64*i +: 64], m[i]);
      chk(tag, win_mask_o[64*i +: 64], m[i+4]);
      chk(tag, xlat_base_o[64*i +: 64], m[i+8]);
    end
    chk(tag, ctrl_o, m[12]);
  endtask

  function automatic void model(input bit wr, input logic [31:0] a, input logic [3:0] sz,
                                output bit ok, output logic [63:0] rd);
    int s;
    ok = 0; rd = 0;
    if (a < BASE || a >= BASE + 32'd4096 || sz != 4'd8) return;
    s = int'((a - BASE) >> 6);
    if (s <= 12) begin ok = 1; if (!wr) rd = m[s]; end
    else if (s == 15 || s == 19) ok = 1;
    else if (s == 16) ok = !wr;
  endfunction

  task automatic access(input string tag, input bit wr, input logic [31:0] a,
                        input logic [3:0] sz, input logic [63:0] d);
    bit ok; logic [63:0] rd;
    model(wr, a, sz, ok, rd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " err"}, 64'(rsp_err), 64'(!ok));
    chk({tag, " rdata"}, rsp_rdata, rd);
    if (wr && ok && ((a - BASE) >> 6) <= 12) m[(a - BASE) >> 6] = d;
    chk_outputs({tag, " regs"});
  endtask

  function automatic logic [31:0] slot(input int s);
    return BASE + 32'(s * 64);
  endfunction

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 12; i++) m[i] = 0;
    m[12] = CRST;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk_outputs("R1 reset");
    access("R4 ctrl read", 0, slot(12), 8, 0);
    // R2: low six bits ignored
    access("R2 write slot0", 1, slot(0) + 32'h3f, 8, 64'hdead_beef_0123_4567);
    access("R4 read slot0", 0, slot(0) + 32'h08, 8, 0);
    for (int s = 0; s < 13; s++)
      access("R3 fill", 1, slot(s), 8, {$urandom, $urandom});
    for (int s = 0; s < 13; s++)
      access("R4 readback", 0, slot(s), 8, 0);
    access("R5 errstat wr", 1, slot(15), 8, '1);
    access("R5 errstat rd", 0, slot(15), 8, 0);
    access("R6 inval wr", 1, slot(19), 8, '1);
    access("R6 inval rd", 0, slot(19), 8, 0);
    access("R7 errmask wr", 1, slot(16), 8, '1);
    access("R7 errmask rd", 0, slot(16), 8, 0);
    access("R8 slot13 wr", 1, slot(13), 8, '1);
    access("R8 slot21 rd", 0, slot(21), 8, 0);
    access("R8 slot63 wr", 1, slot(63), 8, '1);
    access("R9 size4 wr", 1, slot(3), 4, '1);
    access("R9 size4 rd", 0, slot(3), 4, 0);
    access("R10 below", 1, BASE - 32'd64, 8, '1);
    access("R10 above alias", 1, BASE + 32'd4096, 8, '1);
    @(negedge clk);
    chk("R11 idle", 64'(rsp_valid), 64'd0);
    for (int n = 0; n < 400; n++) begin
      int r; logic [31:0] a; logic [3:0] sz;
      r = int'($urandom % 16);
      a = slot(int'($urandom % 24)) + ($urandom % 64);
      if (r == 0) a = $urandom;
      sz = (r == 1) ? 4'($urandom) : 4'd8;
      access("R8 random", 1'($urandom), a, sz, {$urandom, $urandom});
      if (r == 2) begin
        @(negedge clk);
        chk("R11 random idle", 64'(rsp_valid), 64'd0);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule